// File: doc/BRIEF.md
# Linked-List Transmit DMA Engine

This block is the transmit half of one DMA channel. Given the address of a first data descriptor and the address of an enclosing context descriptor, it walks a chain of data descriptors in memory. For each descriptor it reads the bytes from the buffer start pointer up to, but not including, the end pointer. It presents them one per beat on a byte stream, and it flags end-of-packet on the final byte when the descriptor asks for it. Before the first byte of each packet it presents the descriptor's 16-bit metadata on a separate sideband stream.

When a buffer is used up, the engine writes the descriptor back, raises a sticky descriptor interrupt if requested, and then either follows the next pointer or, at end-of-list, marks the context disabled and parks in an eol state. It stays there until it is started again. Memory is reached through a plain 32-bit word port that completes one access per acknowledge.

Both outgoing streams follow valid/ready rules. Once valid is high, the payload is held stable and valid stays high until the cycle in which ready is also high, and that cycle is the transfer. A consumer may hold ready low for any number of cycles and no byte or metadata word is lost or repeated. The engine never waits for ready before raising valid.

Top module: `dma_tx_walker`

## Requirements
- R1: A descriptor is fetched as four word reads at ptr, ptr+4, ptr+8 and ptr+12, holding in order the next pointer, the buffer start, the flags word and the buffer end. The flags fields are: bit 0 end-of-list, bit 3 end-of-packet, bit 4 interrupt request, bits 31:16 metadata.
- R2: The bytes at addresses start .. end-1 appear on st_data in ascending address order, and the byte at address a is bits 8*(a mod 4)+7 : 8*(a mod 4) of the word at a with its low two bits cleared. Start and end may be unaligned.
- R3: st_last is high only on the byte at address end-1, and only when that descriptor's end-of-packet flag is set.
- R4: The metadata field is sent once on md_data after each start, and again after each descriptor that completes with end-of-packet set. No metadata is sent for any other descriptor.
- R5: While st_valid or md_valid is high and its ready is low, valid stays high and the data, including st_last, stays unchanged.
- R6: After BURST_MAX bytes of one descriptor without reaching its end, the descriptor is fetched again (four reads) and transfer resumes at the current position.
- R7: irq_desc is set when a descriptor with its interrupt flag completes. It stays set until irq_clr is pulsed.
- R8: A completed descriptor is written back with four word writes, unchanged, to the same four addresses.
- R9: At end-of-list the flags word at ctx+4 is read and written back with bit 15 set. Then eol_state goes high, busy goes low, and neither memory nor stream activity occurs until the next start.
- R10: When end-of-list is clear, cur_desc takes the next pointer, that descriptor is fetched, and transfer starts from its buffer start.
- R11: A descriptor whose start equals its end sends no bytes and completes normally.
- R12: After reset busy, eol_state, irq_desc, mem_req, st_valid and md_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| start_desc | input | 32 | First data descriptor address |
| start_ctx | input | 32 | Context descriptor address |
| busy | output | 1 | Chain walk in progress |
| eol_state | output | 1 | End-of-list reached, channel stopped |
| cur_desc | output | 32 | Address of the descriptor being handled |
| irq_desc | output | 1 | Sticky descriptor-complete interrupt |
| irq_clr | input | 1 | Clears irq_desc |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| md_valid | output | 1 | Metadata word valid |
| md_ready | input | 1 | Metadata consumer ready |
| md_data | output | 16 | Metadata word |
| st_valid | output | 1 | Stream byte valid |
| st_ready | input | 1 | Stream consumer ready |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | End-of-packet marker |

## Verification
A corrupted position or end register shows at the ports within one beat: a wrong byte value, or st_last on the wrong byte, compared against bytes computed from the address. A lost pending-metadata flag shows as a missing or extra md_data word at the next packet boundary. A wrong burst counter shows as the wrong number of descriptor re-reads on the memory port. A stuck eol flag shows as a stalled chain or as memory traffic after the stop, in the cycles that follow the context write.

// File: rtl/dmatx_pkg.sv
package dmatx_pkg;
  localparam int WORD_W = 32;

  localparam int FL_EOL  = 0;
  localparam int FL_EOP  = 3;
  localparam int FL_INTR = 4;
  localparam int FL_MD_LO = 16;
  localparam int CTX_DIS = 15;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_MD, S_CHECK, S_RDW, S_EMIT, S_WB, S_CTXR, S_CTXW
  } walk_state_t;
endpackage

// File: rtl/dmatx_desc.sv
module dmatx_desc
  import dmatx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        cap_idx,
  input  logic [WORD_W-1:0] cap_word,
  input  logic [1:0]        rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] d_next,
  output logic [WORD_W-1:0] d_start,
  output logic [WORD_W-1:0] d_end,
  output logic              f_eol,
  output logic              f_eop,
  output logic              f_intr,
  output logic [15:0]       f_md
);
  logic [WORD_W-1:0] words [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) words[i] <= '0;
    end else if (cap_en) begin
      words[cap_idx] <= cap_word;
    end
  end

  assign rd_word = words[rd_idx];
  assign d_next  = words[0];
  assign d_start = words[1];
  assign d_end   = words[3];
  assign f_eol   = words[2][FL_EOL];
  assign f_eop   = words[2][FL_EOP];
  assign f_intr  = words[2][FL_INTR];
  assign f_md    = words[2][FL_MD_LO +: 16];
endmodule

// File: rtl/dmatx_lane.sv
module dmatx_lane
  import dmatx_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        ofs,
  input  logic              last_byte,
  input  logic              eop_flag,
  output logic [7:0]        byte_out,
  output logic              last_out
);
  always_comb begin
    byte_out = word[8*ofs +: 8];
    last_out = eop_flag && last_byte;
  end
endmodule

// File: rtl/dma_tx_walker.sv
module dma_tx_walker
  import dmatx_pkg::*;
#(
  parameter int BURST_MAX = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_desc,
  input  logic [31:0] start_ctx,
  output logic        busy,
  output logic        eol_state,
  output logic [31:0] cur_desc,
  output logic        irq_desc,
  input  logic        irq_clr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        md_valid,
  input  logic        md_ready,
  output logic [15:0] md_data,
  output logic        st_valid,
  input  logic        st_ready,
  output logic [7:0]  st_data,
  output logic        st_last
);
  localparam int CW = $clog2(BURST_MAX + 1);
  localparam logic [CW-1:0] CAP = CW'(BURST_MAX);

  walk_state_t state;
  logic [1:0]        idx;
  logic [WORD_W-1:0] desc_ptr, ctx_ptr, pos, wbuf;
  logic [CW-1:0]     chunk;
  logic              md_pend, eol_q, irq_q, refetch;

  logic [WORD_W-1:0] d_next, d_start, d_end, rd_word;
  logic              f_eol, f_eop, f_intr;
  logic [15:0]       f_md;
  logic              cap_en, at_end_next, beat;

  assign cap_en      = (state == S_FETCH) && mem_ack;
  assign at_end_next = (pos + 32'd1) == d_end;
  assign beat        = st_valid && st_ready;

  dmatx_desc u_desc (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(idx),
    .cap_word(mem_rdata), .rd_idx(idx), .rd_word(rd_word),
    .d_next(d_next), .d_start(d_start), .d_end(d_end),
    .f_eol(f_eol), .f_eop(f_eop), .f_intr(f_intr), .f_md(f_md)
  );

  dmatx_lane u_lane (
    .word(wbuf), .ofs(pos[1:0]), .last_byte(at_end_next),
    .eop_flag(f_eop), .byte_out(st_data), .last_out(st_last)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_ptr + {28'd0, idx, 2'b00};
      end
      S_RDW: begin
        mem_req  = 1'b1;
        mem_addr = {pos[31:2], 2'b00};
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_ptr + {28'd0, idx, 2'b00};
        mem_wdata = rd_word;
      end
      S_CTXR: begin
        mem_req  = 1'b1;
        mem_addr = ctx_ptr + 32'd4;
      end
      S_CTXW: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ctx_ptr + 32'd4;
        mem_wdata = wbuf;
      end
      default: ;
    endcase
  end

  assign st_valid  = (state == S_EMIT);
  assign md_valid  = (state == S_MD);
  assign md_data   = f_md;
  assign busy      = (state != S_IDLE);
  assign eol_state = eol_q;
  assign cur_desc  = desc_ptr;
  assign irq_desc  = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      desc_ptr <= '0;
      ctx_ptr  <= '0;
      pos      <= '0;
      wbuf     <= '0;
      chunk    <= '0;
      md_pend  <= 1'b0;
      eol_q    <= 1'b0;
      irq_q    <= 1'b0;
      refetch  <= 1'b0;
    end else begin
      if (irq_clr) irq_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          desc_ptr <= start_desc;
          ctx_ptr  <= start_ctx;
          eol_q    <= 1'b0;
          md_pend  <= 1'b1;
          refetch  <= 1'b0;
          idx      <= '0;
          state    <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) begin
            chunk <= '0;
            if (!refetch) pos <= d_start;
            state <= md_pend ? S_MD : S_CHECK;
          end
        end
        S_MD: if (md_ready) begin
          md_pend <= 1'b0;
          state   <= S_CHECK;
        end
        S_CHECK: begin
          if (pos == d_end) begin
            if (f_intr) irq_q <= 1'b1;
            if (f_eop) md_pend <= 1'b1;
            idx   <= '0;
            state <= S_WB;
          end else if (chunk == CAP) begin
            refetch <= 1'b1;
            idx     <= '0;
            state   <= S_FETCH;
          end else begin
            state <= S_RDW;
          end
        end
        S_RDW: if (mem_ack) begin
          wbuf  <= mem_rdata;
          state <= S_EMIT;
        end
        S_EMIT: if (st_ready) begin
          pos   <= pos + 32'd1;
          chunk <= chunk + CW'(1);
          if (at_end_next || pos[1:0] == 2'd3 || (chunk + CW'(1)) == CAP)
            state <= S_CHECK;
        end
        S_WB: if (mem_ack) begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) begin
            if (f_eol) begin
              state <= S_CTXR;
            end else begin
              desc_ptr <= d_next;
              refetch  <= 1'b0;
              state    <= S_FETCH;
            end
          end
        end
        S_CTXR: if (mem_ack) begin
          wbuf  <= mem_rdata | (32'd1 << CTX_DIS);
          state <= S_CTXW;
        end
        S_CTXW: if (mem_ack) begin
          eol_q <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last)); // R5
  AST_MD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    md_valid && !md_ready |=> md_valid && $stable(md_data)); // R5
  AST_EOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    eol_state |-> !mem_req && !st_valid && !md_valid); // R9
  AST_LAST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_last |-> (pos + 32'd1) == d_end && f_eop); // R3
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> chunk < CAP); // R6
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R1
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_desc && !irq_clr |=> irq_desc); // R7
endmodule

// File: tb/dma_tx_walker_tb.sv
module dma_tx_walker_tb;
  localparam int CLK_P = 10;
  localparam int BMAX  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] start_desc = '0, start_ctx = '0;
  logic busy, eol_state, irq_desc;
  logic irq_clr = 1'b0;
  logic [31:0] cur_desc;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic md_valid, md_ready, st_valid, st_ready, st_last;
  logic [15:0] md_data;
  logic [7:0] st_data;

  always #(CLK_P/2) clk = ~clk;

  dma_tx_walker #(.BURST_MAX(BMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_desc(start_desc),
    .start_ctx(start_ctx), .busy(busy), .eol_state(eol_state),
    .cur_desc(cur_desc), .irq_desc(irq_desc), .irq_clr(irq_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .md_valid(md_valid), .md_ready(md_ready), .md_data(md_data),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .st_last(st_last)
  );

  int vectors = 0;
  int fails = 0;
  int desc_writes = 0, ctx_writes = 0, d4_reads = 0;
  logic [31:0] mem [1024];
  logic [8:0]  exp_st [$];
  logic [15:0] exp_md [$];
  logic [7:0]  lfsr = 8'h5A;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 8'hFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_bytes(input int a0, input int a1, input bit eop);
    for (int a = a0; a < a1; a++) exp_st.push_back({eop && (a == a1 - 1), pat(a)});
  endtask

  task automatic set_desc(input int at, input logic [31:0] nx, input logic [31:0] b,
                          input logic [31:0] fl, input logic [31:0] e);
    mem[at >> 2] = nx; mem[(at >> 2) + 1] = b;
    mem[(at >> 2) + 2] = fl; mem[(at >> 2) + 3] = e;
  endtask

  task automatic run(input logic [31:0] d, input logic [31:0] c);
    @(negedge clk);
    start_desc = d; start_ctx = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // memory model: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_we) begin
          mem[mem_addr[11:2]] <= mem_wdata;
          if (mem_addr >= 32'h100 && mem_addr < 32'h120) desc_writes++;
          else ctx_writes++;
        end else if (mem_addr >= 32'h140 && mem_addr < 32'h150) d4_reads++;
      end
    end
  end

  // ready pattern and scoreboard monitor
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    st_ready = lfsr[0] | lfsr[3];
    md_ready = lfsr[1];
    if (rst_n && st_valid && st_ready) begin
      if (exp_st.size() == 0) check("R2 unexpected byte", {23'd0, st_last, st_data}, 32'h1FF);
      else begin
        logic [8:0] e;
        e = exp_st.pop_front();
        check("R2 byte", {24'd0, st_data}, {24'd0, e[7:0]});
        check("R3 last", {31'd0, st_last}, {31'd0, e[8]});
      end
    end
    if (rst_n && md_valid && md_ready) begin
      if (exp_md.size() == 0) check("R4 unexpected metadata", {16'd0, md_data}, 32'hFFFFFFFF);
      else check("R4 metadata", {16'd0, md_data}, {16'd0, exp_md.pop_front()});
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL R12 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    st_ready = 1'b0; md_ready = 1'b0;
    for (int w = 0; w < 1024; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    set_desc(32'h100, 32'h110, 32'h201, 32'hAAAA0010, 32'h20A);
    set_desc(32'h110, 32'h777, 32'h300, 32'hBBBB0009, 32'h306);
    mem[32'h184 >> 2] = 32'h1;
    set_desc(32'h120, 32'h130, 32'h400, 32'hCCCC0008, 32'h403);
    set_desc(32'h130, 32'h999, 32'h500, 32'hDDDD0001, 32'h500);
    mem[32'h194 >> 2] = 32'h0;
    set_desc(32'h140, 32'h888, 32'h600, 32'hEEEE0009, 32'h628);
    mem[32'h1A4 >> 2] = 32'h0;

    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 busy", {31'd0, busy}, 32'd0);
    check("R12 eol_state", {31'd0, eol_state}, 32'd0);
    check("R12 irq", {31'd0, irq_desc}, 32'd0);
    check("R12 outputs", {29'd0, mem_req, st_valid, md_valid}, 32'd0);
    rst_n = 1'b1;

    // run 1: unaligned buffer then packet end, R1 R2 R3 R10
    exp_md.push_back(16'hAAAA);
    push_bytes(32'h201, 32'h20A, 1'b0);
    push_bytes(32'h300, 32'h306, 1'b1);
    run(32'h100, 32'h180);
    check("R2 all bytes sent", exp_st.size(), 0);
    check("R4 only one metadata", exp_md.size(), 0);
    check("R10 cur_desc follows next", cur_desc, 32'h110);
    check("R7 irq set", {31'd0, irq_desc}, 32'd1);
    check("R8 descriptor writes", desc_writes, 8);
    check("R8 descriptor unchanged", mem[32'h108 >> 2], 32'hAAAA0010);
    check("R9 context disabled", mem[32'h184 >> 2], 32'h00008001);
    check("R9 context writes", ctx_writes, 1);
    check("R9 eol_state", {31'd0, eol_state}, 32'd1);
    begin
      int act = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (mem_req || st_valid || md_valid) act++;
      end
      check("R9 quiet after stop", act, 0);
    end
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check("R7 irq cleared", {31'd0, irq_desc}, 32'd0);

    // run 2: packet end then zero-length descriptor, R4 R11
    exp_md.push_back(16'hCCCC);
    push_bytes(32'h400, 32'h403, 1'b1);
    exp_md.push_back(16'hDDDD);
    run(32'h120, 32'h190);
    check("R11 bytes sent", exp_st.size(), 0);
    check("R4 metadata after packet end", exp_md.size(), 0);
    check("R11 completes at eol", cur_desc, 32'h130);
    check("R7 no irq without flag", {31'd0, irq_desc}, 32'd0);
    check("R9 context bit", mem[32'h194 >> 2], 32'h00008000);

    // run 3: burst cap re-fetch, R6
    exp_md.push_back(16'hEEEE);
    push_bytes(32'h600, 32'h628, 1'b1);
    run(32'h140, 32'h1A0);
    check("R6 bytes sent", exp_st.size(), 0);
    check("R6 descriptor reads", d4_reads, 12);
    check("R6 single metadata", exp_md.size(), 0);
    check("R9 eol after run", {31'd0, eol_state}, 32'd1);

    finish_run();
  end
endmodule